// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Controller

This block times the power switch of a free-running flyback converter that uses peak-current control. It has no oscillator. An off period always starts with a fixed blank. After the blank, the switch may turn on again at the next valley of the winding ringing, which the block sees as a falling edge of a digitized core-reset comparator flag. If the ringing has died out, a restart timeout gives the permission instead. A permission that arrives while the light-load hold flag is set is not used. The block waits for the flag to clear, and this is what produces bursts of pulses at light load.

An on period ends when the peak-current comparator trips. The trip is ignored for a short blanking window right after turn-on. A bias-enable output follows the inverse of the gate, so an external offset current source is active whenever the switch is off. A halt input, driven by fault or latch logic, pulls the gate low in the same cycle. When halt is released, a full off-time blank runs again. All intervals are parameters counted in clock cycles.

Top module: `qr_cycle_ctrl`

## Requirements
- R1: While rstN is low, gateOnOut is 0 and senseBiasEnOut is 1. The off-time blank starts counting at the first cycle after reset is released.
- R2: After gateOnOut falls, it stays low for at least MIN_OFF_CYC+1 cycles. A core-reset crossing that occurs during this blank does not turn the switch on.
- R3: A core-reset crossing is a cycle in which coreResetIn is 0 and was 1 in the previous cycle. If a crossing occurs once the blank has elapsed, gateOnOut rises in the next cycle, provided the hold flag is clear.
- R4: A ringing timer restarts on every crossing and on every turn-off. If it reaches RING_TIMEOUT_CYC cycles once the blank has elapsed, that also grants the turn-on permission.
- R5: If burstHoldIn is 1 when permission is granted, gateOnOut stays low. It rises in the cycle after the first cycle in which burstHoldIn is seen at 0.
- R6: peakTripIn has no effect during the first BLANK_CYC cycles of an on period. The shortest possible on period is BLANK_CYC+1 cycles.
- R7: If peakTripIn is 1 after the blanking window, gateOnOut falls in the next cycle.
- R8: senseBiasEnOut is the inverse of gateOnOut in every cycle.
- R9: haltIn = 1 drives gateOnOut low in the same cycle and keeps it low. After release, the switch cannot turn on for MIN_OFF_CYC+1 cycles, counted from the first cycle with haltIn at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| haltIn | input | 1 | Fault or latch disable; forces the gate low |
| coreResetIn | input | 1 | Digitized core-reset comparator (1 = winding above threshold) |
| peakTripIn | input | 1 | Peak-current comparator trip, level |
| burstHoldIn | input | 1 | Light-load hold condition, level |
| gateOnOut | output | 1 | Power switch gate-drive enable |
| senseBiasEnOut | output | 1 | Enable for the sense-pin offset current source |

## Verification
The bench runs off periods under four conditions: no ringing at all, ringing with valleys every few cycles that outlast the blank, a single late crossing, and a hold flag that spans the moment of permission. Each condition yields a different off-period length, so the measured length shows which source granted the restart: the blank, a valley, a timeout rearmed by a crossing, or the release of the hold flag. On periods are run with the trip held from the start, with the trip asserted late, and with a trip pulse that falls inside the blanking window. This separates trips that are ignored during blanking from trips that end the pulse. A halt asserted in the middle of a pulse checks both the same-cycle cutoff and the renewed blank after release.

// File: rtl/qr_pkg.sv
package qr_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_PEND = 2'd1,
    ST_ON   = 2'd2
  } qrState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic startOff;
    logic startOn;
  } qrStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic offDone;
    logic timeoutHit;
    logic blankDone;
    logic ringFall;
  } qrStatus_t;

endpackage

// File: rtl/qr_satcnt.sv
module qr_satcnt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      count <= '0;
    end else if (count != LIM) begin
      count <= count + W'(1);
    end
  end

  assign done = (count == LIM);

endmodule

// File: rtl/qr_timers.sv
module qr_timers
  import qr_pkg::*;
#(
  parameter int MIN_OFF_CYC      = 800,
  parameter int RING_TIMEOUT_CYC = 500,
  parameter int BLANK_CYC        = 38
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      coreResetIn,
  input  qrStrobe_t strobe,
  output qrStatus_t status
);
  localparam int NUM_TMR = 3;
  localparam int LIMITS [NUM_TMR] = '{MIN_OFF_CYC, RING_TIMEOUT_CYC, BLANK_CYC};

  logic ringPrev;
  logic ringFall;
  logic [NUM_TMR-1:0] tmrClear;
  logic [NUM_TMR-1:0] tmrDone;

  always_ff @(posedge clk) begin
    if (!rstN) ringPrev <= 1'b0;
    else       ringPrev <= coreResetIn;
  end

  assign ringFall = ringPrev & ~coreResetIn;

  // index 0: off-time blank, 1: ringing timeout, 2: leading-edge blank
  assign tmrClear[0] = strobe.startOff;
  assign tmrClear[1] = strobe.startOff | ringFall;
  assign tmrClear[2] = strobe.startOn;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    qr_satcnt #(.LIMIT(LIMITS[g])) i_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .clear (tmrClear[g]),
      .done  (tmrDone[g])
    );
  end

  assign status.offDone    = tmrDone[0];
  assign status.timeoutHit = tmrDone[1];
  assign status.blankDone  = tmrDone[2];
  assign status.ringFall   = ringFall;

  // R2: a new off period always restarts the blank
  assert_blank_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startOff |=> !status.offDone);

  // R4: a crossing always rearms the ringing timeout
  assert_timeout_rearm_R4: assert property (@(posedge clk) disable iff (!rstN)
    ringFall |=> !status.timeoutHit);

endmodule

// File: rtl/qr_ctrl.sv
module qr_ctrl
  import qr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      haltIn,
  input  logic      peakTripIn,
  input  logic      burstHoldIn,
  input  qrStatus_t status,
  output qrStrobe_t strobe,
  output logic      isOn
);
  qrState_e state, nxtState;
  logic permit;

  assign permit = status.offDone & (status.ringFall | status.timeoutHit);

  always_comb begin
    nxtState = state;
    strobe   = '0;
    if (haltIn) begin
      nxtState        = ST_WAIT;
      strobe.startOff = 1'b1;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (permit) begin
            if (burstHoldIn) begin
              nxtState = ST_PEND;
            end else begin
              nxtState       = ST_ON;
              strobe.startOn = 1'b1;
            end
          end
        end
        ST_PEND: begin
          if (!burstHoldIn) begin
            nxtState       = ST_ON;
            strobe.startOn = 1'b1;
          end
        end
        ST_ON: begin
          if (status.blankDone && peakTripIn) begin
            nxtState        = ST_WAIT;
            strobe.startOff = 1'b1;
          end
        end
        default: nxtState = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= nxtState;
  end

  assign isOn = (state == ST_ON);

  // R2: turn-on only once the blank has elapsed
  assert_on_after_blank_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isOn) |-> $past(status.offDone));

  // R5: hold flag keeps the switch off
  assert_hold_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!isOn && burstHoldIn) |=> !isOn);

  // R6: no turn-off inside the leading-edge blank unless halted
  assert_leb_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (isOn && !status.blankDone && !haltIn) |=> isOn);

  // R7: trip after blanking ends the pulse
  assert_trip_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (isOn && status.blankDone && peakTripIn) |=> !isOn);

  // R9: halt leaves the controller waiting
  assert_halt_wait_R9: assert property (@(posedge clk) disable iff (!rstN)
    haltIn |=> (state == ST_WAIT));

endmodule

// File: rtl/qr_cycle_ctrl.sv
module qr_cycle_ctrl
  import qr_pkg::*;
#(
  parameter int MIN_OFF_CYC      = 800,
  parameter int RING_TIMEOUT_CYC = 500,
  parameter int BLANK_CYC        = 38
) (
  input  logic clk,
  input  logic rstN,
  input  logic haltIn,
  input  logic coreResetIn,
  input  logic peakTripIn,
  input  logic burstHoldIn,
  output logic gateOnOut,
  output logic senseBiasEnOut
);
  qrStrobe_t strobe;
  qrStatus_t status;
  logic isOn;

  qr_timers #(
    .MIN_OFF_CYC      (MIN_OFF_CYC),
    .RING_TIMEOUT_CYC (RING_TIMEOUT_CYC),
    .BLANK_CYC        (BLANK_CYC)
  ) i_timers (
    .clk         (clk),
    .rstN        (rstN),
    .coreResetIn (coreResetIn),
    .strobe      (strobe),
    .status      (status)
  );

  qr_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .haltIn      (haltIn),
    .peakTripIn  (peakTripIn),
    .burstHoldIn (burstHoldIn),
    .status      (status),
    .strobe      (strobe),
    .isOn        (isOn)
  );

  assign gateOnOut      = isOn & ~haltIn;
  assign senseBiasEnOut = ~gateOnOut;

endmodule

// File: tb/test_qr_cycle_ctrl.sv
module test_qr_cycle_ctrl;

  localparam int MINOFF = 16;
  localparam int TOUT   = 10;
  localparam int BLK    = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltIn = 1'b0;
  logic coreResetIn = 1'b0;
  logic peakTripIn = 1'b1;
  logic burstHoldIn = 1'b0;
  logic gateOnOut;
  logic senseBiasEnOut;

  always #5 clk = ~clk;

  qr_cycle_ctrl #(
    .MIN_OFF_CYC      (MINOFF),
    .RING_TIMEOUT_CYC (TOUT),
    .BLANK_CYC        (BLK)
  ) i_qr_cycle_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .haltIn         (haltIn),
    .coreResetIn    (coreResetIn),
    .peakTripIn     (peakTripIn),
    .burstHoldIn    (burstHoldIn),
    .gateOnOut      (gateOnOut),
    .senseBiasEnOut (senseBiasEnOut)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit monOn = 1'b0;

  // scoreboard: expected gate runs (level, length in cycles, tag)
  int    expLvl[$];
  int    expLen[$];
  string expTag[$];

  task automatic expectRun(input int lvl, input int len, input string tag);
    expLvl.push_back(lvl);
    expLen.push_back(len);
    expTag.push_back(tag);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic waitFall();
    @(negedge gateOnOut);
    #2;
  endtask

  // monitor
  logic prevGate = 1'b0;
  int   runLen = 0;
  always @(negedge clk) begin
    if (monOn) begin
      total++;
      if (senseBiasEnOut !== ~gateOnOut) begin
        bad++;
        $display("FAIL R8: bias enable=%b expected=%b", senseBiasEnOut, ~gateOnOut);
      end
      if (gateOnOut === prevGate) begin
        runLen++;
      end else begin
        total++;
        if (expLvl.size() == 0) begin
          bad++;
          $display("FAIL unexpected run: level=%0d len=%0d expected none", prevGate, runLen);
        end else begin
          int    eL;
          int    eN;
          string eT;
          eL = expLvl.pop_front();
          eN = expLen.pop_front();
          eT = expTag.pop_front();
          if (eL != int'(prevGate) || eN != runLen)
            $display("FAIL %s: level=%0d len=%0d expected level=%0d len=%0d",
                     eT, prevGate, runLen, eL, eN);
          if (eL != int'(prevGate) || eN != runLen) bad++;
        end
        prevGate = gateOnOut;
        runLen = 1;
      end
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    total++;
    if (gateOnOut !== 1'b0 || senseBiasEnOut !== 1'b1) begin
      bad++;
      $display("FAIL R1: gate=%b bias=%b expected gate=0 bias=1", gateOnOut, senseBiasEnOut);
    end
    @(posedge clk); #2;
    rstN = 1'b1;
    monOn = 1'b1;

    // S1 R1 R4: no ringing, timeout already reached when blank ends
    expectRun(0, MINOFF + 1, "R1 R4 first off");
    expectRun(1, BLK + 1, "R6 trip held from start");

    // S2 R2 R3: valleys at 5,10,15 ignored, valley at 20 used
    expectRun(0, 21, "R2 R3 valley restart");
    expectRun(1, BLK + 1, "R6 trip held");
    waitFall();
    coreResetIn = 1'b1;
    step(5);  coreResetIn = 1'b0;
    step(1);  coreResetIn = 1'b1;
    step(4);  coreResetIn = 1'b0;
    step(1);  coreResetIn = 1'b1;
    step(4);  coreResetIn = 1'b0;
    step(1);  coreResetIn = 1'b1;
    step(4);  coreResetIn = 1'b0;

    // S3 R4: one late crossing rearms the timeout
    expectRun(0, 26, "R4 timeout rearmed by crossing");
    expectRun(1, BLK + 1, "R6 trip held");
    waitFall();
    coreResetIn = 1'b1;
    step(14); coreResetIn = 1'b0;

    // S4 R5: hold flag over the permission point
    expectRun(0, 31, "R5 hold released late");
    expectRun(1, BLK + 1, "R6 trip held");
    waitFall();
    burstHoldIn = 1'b1;
    step(30); burstHoldIn = 1'b0;

    // S6 R7: trip arrives late in the pulse
    expectRun(0, MINOFF + 1, "R2 blank only");
    expectRun(1, 10, "R7 late trip");
    waitFall();
    peakTripIn = 1'b0;
    step(MINOFF + 1);
    step(9);  peakTripIn = 1'b1;

    // S7 R6: trip pulse inside blanking ignored
    expectRun(0, MINOFF + 1, "R2 blank only");
    expectRun(1, 8, "R6 trip in blank ignored R7");
    waitFall();
    peakTripIn = 1'b0;
    step(MINOFF + 1);
    step(1);  peakTripIn = 1'b1;
    step(2);  peakTripIn = 1'b0;
    step(4);  peakTripIn = 1'b1;

    // S8 R9: halt mid-pulse, then full blank after release
    expectRun(0, MINOFF + 1, "R2 blank only");
    expectRun(1, 2, "R9 halt cuts pulse");
    expectRun(0, 22, "R9 blank after release");
    expectRun(1, BLK + 1, "R6 trip held");
    waitFall();
    peakTripIn = 1'b0;
    step(MINOFF + 1);
    step(2);  haltIn = 1'b1;
    step(5);  haltIn = 1'b0; peakTripIn = 1'b1;

    waitFall();
    step(5);
    total++;
    if (expLvl.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: %0d runs left expected 0", expLvl.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule